// File: doc/BRIEF.md
# Three-Level Interrupt Combiner with Shared-Pin Routing

This block collects the error flags raised by the temperature, voltage-rail and fan-speed monitors and reduces them to one active-low interrupt. Each flag must pass three gates before it can request an interrupt: a per-flag mask bit, a mask bit for its class (temperature, voltage or fan), and one master bit. The combined request is registered, so the interrupt stays low for as long as any enabled flag remains set. Diode-fault flags from the remote sensors never take part in this reduction. They only appear in a read-only register.

No pin is dedicated to the interrupt. It can be placed on either of two pads that normally carry something else. One pad is normally a PWM output. The other is normally a tachometer input. A configuration register chooses, for each pad, whether it keeps its normal role or carries the interrupt level. A simple byte-wide register port, with a write strobe and a combinational read, holds all the masks and the routing bits.

Top module: `irqCombiner`

## Requirements
- R1: `irqN` is active low. It changes one clock edge after its inputs change. It stays low for as long as at least one flag is set whose per-flag, class and master enables are all 1.
- R2: The master enable is bit 2 of address 0x7C. While it is 0, `irqN` stays 1 whatever the flags and the other masks hold.
- R3: Temperature flag i (i = 0..2) is enabled by bit i+1 of address 0x82. Bit 0 of 0x82 is the temperature class enable.
- R4: The eight voltage flags are formed as `{voltStatusB, voltStatusA}`, with rails 0..4 in A and rails 5..7 in B. Both groups take part in the reduction. Rail i is enabled by bit i of address 0x85. Bit 0 of 0x7E is the voltage class enable.
- R5: Fan flag i (i = 0..3) is enabled by bit i+1 of address 0x80. Bit 0 of 0x80 is the fan class enable.
- R6: `diodeFault` has no effect on `irqN`. Its value reads back on bits 2:0 of address 0x86.
- R7: When bit 1 of 0x7F is 1, `pwm2Pad` carries the `irqN` level. When that bit is 0, `pwm2Pad` carries `pwm2Gen`. `pwm2Oe` is always 1.
- R8: When bit 0 of 0x7F is 1, `tach3Oe` is 1, `tach3PadOut` carries the `irqN` level and `tach3ToMon` is held at 1. When that bit is 0, `tach3Oe` is 0, `tach3PadOut` is 0 and `tach3ToMon` follows `tach3PadIn`.
- R9: After reset, every enable and routing bit is 0, `irqN` is 1 and every writable register reads 0.
- R10: Writable registers read back the bits they hold, and their unused bits read 0. Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| tempStatus | input | 3 | Temperature limit flags |
| voltStatusA | input | 5 | Voltage flags, rails 0..4 |
| voltStatusB | input | 3 | Voltage flags, rails 5..7 |
| fanStatus | input | 4 | Fan tachometer error flags |
| diodeFault | input | 3 | Remote diode fault flags (read only) |
| pwm2Gen | input | 1 | Normal PWM value for the shared PWM pad |
| tach3PadIn | input | 1 | Value sensed on the shared tach pad |
| irqN | output | 1 | Active-low interrupt level |
| pwm2Pad | output | 1 | Output value for the shared PWM pad |
| pwm2Oe | output | 1 | Output enable for the shared PWM pad |
| tach3PadOut | output | 1 | Output value for the shared tach pad |
| tach3Oe | output | 1 | Output enable for the shared tach pad |
| tach3ToMon | output | 1 | Tach level passed on to the speed monitor |

## Verification
On every cycle, the assertions check four things. The master gate and the temperature class gate force the interrupt off on the following cycle. An interrupt cannot arise when no monitor flag is set, whatever the diode faults are doing. A routed pad mirrors the interrupt, and at most one register is written in a cycle. The exact AND-of-three-masks arithmetic for every flag, the read-back of each field, and the pass-through of the PWM and tach signals when they are not routed can only be shown by the bench's sweeps. Those sweeps cover all mask and flag combinations of the temperature and fan classes, a wide voltage sample, and every routing setting.

// File: rtl/irqCombinerPkg.sv
package irqCombinerPkg;
  localparam logic [7:0] ADDR_MASTER   = 8'h7C;
  localparam logic [7:0] ADDR_VOLT_GRP = 8'h7E;
  localparam logic [7:0] ADDR_ROUTE    = 8'h7F;
  localparam logic [7:0] ADDR_FAN      = 8'h80;
  localparam logic [7:0] ADDR_TEMP     = 8'h82;
  localparam logic [7:0] ADDR_VOLT_IND = 8'h85;
  localparam logic [7:0] ADDR_FAULT    = 8'h86;
  localparam int         MASTER_BIT    = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASTER, SEL_VOLT_GRP, SEL_ROUTE,
    SEL_FAN, SEL_TEMP, SEL_VOLT_IND, SEL_FAULT
  } regSel_e;

  typedef struct packed {
    logic    wrMaster;
    logic    wrVoltGrp;
    logic    wrRoute;
    logic    wrFan;
    logic    wrTemp;
    logic    wrVoltInd;
    regSel_e sel;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqCombinerCtrl.sv
module irqCombinerCtrl
  import irqCombinerPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [7:0]   regAddr,
  output ctrlStrobes_t strobes
);
  regSel_e sel;

  always_comb begin
    unique case (regAddr)
      ADDR_MASTER:   sel = SEL_MASTER;
      ADDR_VOLT_GRP: sel = SEL_VOLT_GRP;
      ADDR_ROUTE:    sel = SEL_ROUTE;
      ADDR_FAN:      sel = SEL_FAN;
      ADDR_TEMP:     sel = SEL_TEMP;
      ADDR_VOLT_IND: sel = SEL_VOLT_IND;
      ADDR_FAULT:    sel = SEL_FAULT;
      default:       sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.sel       = sel;
    strobes.wrMaster  = regWrEn && (sel == SEL_MASTER);
    strobes.wrVoltGrp = regWrEn && (sel == SEL_VOLT_GRP);
    strobes.wrRoute   = regWrEn && (sel == SEL_ROUTE);
    strobes.wrFan     = regWrEn && (sel == SEL_FAN);
    strobes.wrTemp    = regWrEn && (sel == SEL_TEMP);
    strobes.wrVoltInd = regWrEn && (sel == SEL_VOLT_IND);
  end

  // R10: a single write lands in at most one register
  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMaster, strobes.wrVoltGrp, strobes.wrRoute,
              strobes.wrFan, strobes.wrTemp, strobes.wrVoltInd}));
endmodule

// File: rtl/irqCombinerDatapath.sv
module irqCombinerDatapath
  import irqCombinerPkg::*;
#(
  parameter int NUM_TEMP = 3,
  parameter int VOLT_A   = 5,
  parameter int VOLT_B   = 3,
  parameter int NUM_FAN  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [7:0]          wrData,
  input  logic [NUM_TEMP-1:0] tempStatus,
  input  logic [VOLT_A-1:0]   voltStatusA,
  input  logic [VOLT_B-1:0]   voltStatusB,
  input  logic [NUM_FAN-1:0]  fanStatus,
  input  logic [NUM_TEMP-1:0] diodeFault,
  input  logic                pwm2Gen,
  input  logic                tach3PadIn,
  output logic [7:0]          rdData,
  output logic                irqN,
  output logic                pwm2Pad,
  output logic                pwm2Oe,
  output logic                tach3PadOut,
  output logic                tach3Oe,
  output logic                tach3ToMon
);
  localparam int NUM_VOLT = VOLT_A + VOLT_B;

  logic                masterEn;
  logic                voltGrpEn;
  logic [1:0]          routeCfg;
  logic [NUM_FAN:0]    fanCfg;
  logic [NUM_TEMP:0]   tempCfg;
  logic [NUM_VOLT-1:0] voltMask;
  logic [NUM_VOLT-1:0] voltAll;
  logic                tempHit, voltHit, fanHit, irqNext, irqActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn  <= 1'b0;
      voltGrpEn <= 1'b0;
      routeCfg  <= '0;
      fanCfg    <= '0;
      tempCfg   <= '0;
      voltMask  <= '0;
    end else begin
      if (strobes.wrMaster)  masterEn  <= wrData[MASTER_BIT];
      if (strobes.wrVoltGrp) voltGrpEn <= wrData[0];
      if (strobes.wrRoute)   routeCfg  <= wrData[1:0];
      if (strobes.wrFan)     fanCfg    <= wrData[NUM_FAN:0];
      if (strobes.wrTemp)    tempCfg   <= wrData[NUM_TEMP:0];
      if (strobes.wrVoltInd) voltMask  <= wrData[NUM_VOLT-1:0];
    end
  end

  assign voltAll = {voltStatusB, voltStatusA};
  assign tempHit = tempCfg[0] && |(tempStatus & tempCfg[NUM_TEMP:1]);
  assign voltHit = voltGrpEn && |(voltAll & voltMask);
  assign fanHit  = fanCfg[0] && |(fanStatus & fanCfg[NUM_FAN:1]);
  assign irqNext = masterEn && (tempHit || voltHit || fanHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqActive <= 1'b0;
    else       irqActive <= irqNext;
  end

  assign irqN        = !irqActive;
  assign pwm2Oe      = 1'b1;
  assign pwm2Pad     = routeCfg[1] ? irqN : pwm2Gen;
  assign tach3Oe     = routeCfg[0];
  assign tach3PadOut = routeCfg[0] && irqN;
  assign tach3ToMon  = routeCfg[0] ? 1'b1 : tach3PadIn;

  always_comb begin
    rdData = '0;
    unique case (strobes.sel)
      SEL_MASTER:   rdData[MASTER_BIT]   = masterEn;
      SEL_VOLT_GRP: rdData[0]            = voltGrpEn;
      SEL_ROUTE:    rdData[1:0]          = routeCfg;
      SEL_FAN:      rdData[NUM_FAN:0]    = fanCfg;
      SEL_TEMP:     rdData[NUM_TEMP:0]   = tempCfg;
      SEL_VOLT_IND: rdData[NUM_VOLT-1:0] = voltMask;
      SEL_FAULT:    rdData[NUM_TEMP-1:0] = diodeFault;
      default:      rdData = '0;
    endcase
  end

  assert_master_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |=> irqN);

  assert_temp_group_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tempCfg[0] && voltAll == '0 && fanStatus == '0) |=> irqN);

  assert_fault_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tempStatus == '0 && voltAll == '0 && fanStatus == '0) |=> irqN);

  assert_pwm_route_R7: assert property (@(posedge clk) disable iff (!rstN)
    routeCfg[1] |-> (pwm2Pad == irqN));

  assert_tach_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    routeCfg[0] |-> (tach3Oe && tach3PadOut == irqN && tach3ToMon));
endmodule

// File: rtl/irqCombiner.sv
module irqCombiner
  import irqCombinerPkg::*;
#(
  parameter int NUM_TEMP = 3,
  parameter int VOLT_A   = 5,
  parameter int VOLT_B   = 3,
  parameter int NUM_FAN  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [7:0]          regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic [NUM_TEMP-1:0] tempStatus,
  input  logic [VOLT_A-1:0]   voltStatusA,
  input  logic [VOLT_B-1:0]   voltStatusB,
  input  logic [NUM_FAN-1:0]  fanStatus,
  input  logic [NUM_TEMP-1:0] diodeFault,
  input  logic                pwm2Gen,
  input  logic                tach3PadIn,
  output logic                irqN,
  output logic                pwm2Pad,
  output logic                pwm2Oe,
  output logic                tach3PadOut,
  output logic                tach3Oe,
  output logic                tach3ToMon
);
  ctrlStrobes_t strobes;

  irqCombinerCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irqCombinerDatapath #(
    .NUM_TEMP (NUM_TEMP),
    .VOLT_A   (VOLT_A),
    .VOLT_B   (VOLT_B),
    .NUM_FAN  (NUM_FAN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (regWrData),
    .tempStatus  (tempStatus),
    .voltStatusA (voltStatusA),
    .voltStatusB (voltStatusB),
    .fanStatus   (fanStatus),
    .diodeFault  (diodeFault),
    .pwm2Gen     (pwm2Gen),
    .tach3PadIn  (tach3PadIn),
    .rdData      (regRdData),
    .irqN        (irqN),
    .pwm2Pad     (pwm2Pad),
    .pwm2Oe      (pwm2Oe),
    .tach3PadOut (tach3PadOut),
    .tach3Oe     (tach3Oe),
    .tach3ToMon  (tach3ToMon)
  );
endmodule

// File: tb/irqCombiner_bench.sv
module irqCombiner_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [2:0] tempStatus = '0;
  logic [4:0] voltStatusA = '0;
  logic [2:0] voltStatusB = '0;
  logic [3:0] fanStatus = '0;
  logic [2:0] diodeFault = '0;
  logic       pwm2Gen = 1'b0;
  logic       tach3PadIn = 1'b0;
  logic       irqN, pwm2Pad, pwm2Oe, tach3PadOut, tach3Oe, tach3ToMon;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqCombiner u_irqCombiner (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tempStatus(tempStatus),
    .voltStatusA(voltStatusA), .voltStatusB(voltStatusB), .fanStatus(fanStatus),
    .diodeFault(diodeFault), .pwm2Gen(pwm2Gen), .tach3PadIn(tach3PadIn),
    .irqN(irqN), .pwm2Pad(pwm2Pad), .pwm2Oe(pwm2Oe), .tach3PadOut(tach3PadOut),
    .tach3Oe(tach3Oe), .tach3ToMon(tach3ToMon)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 irqN", {7'b0, irqN}, 8'h01);
    check("R9 tach3Oe", {7'b0, tach3Oe}, 8'h00);
    rdCheck("R9 master", 8'h7C, 8'h00);
    rdCheck("R9 temp", 8'h82, 8'h00);
    rdCheck("R9 voltInd", 8'h85, 8'h00);
    rstN = 1'b1;
    settle();

    // R10: read-back and unused bits
    wr(8'h7C, 8'hFF); rdCheck("R10 master", 8'h7C, 8'h04);
    wr(8'h7E, 8'hFF); rdCheck("R10 voltGrp", 8'h7E, 8'h01);
    wr(8'h80, 8'hFF); rdCheck("R10 fan", 8'h80, 8'h1F);
    wr(8'h82, 8'hFF); rdCheck("R10 temp", 8'h82, 8'h0F);
    wr(8'h85, 8'hA5); rdCheck("R10 voltInd", 8'h85, 8'hA5);
    wr(8'h81, 8'h00); wr(8'h7D, 8'h00); wr(8'h86, 8'h00);
    rdCheck("R10 stray write", 8'h82, 8'h0F);
    rdCheck("R10 stray write", 8'h7C, 8'h04);
    rdCheck("R10 unmapped read", 8'h81, 8'h00);
    wr(8'h7C, 8'h00); wr(8'h7E, 8'h00); wr(8'h80, 8'h00);
    wr(8'h82, 8'h00); wr(8'h85, 8'h00);

    // R1 R2 R3: temperature sweep
    for (int g = 0; g < 2; g++)
      for (int cfg = 0; cfg < 16; cfg++) begin
        wr(8'h7C, g[0] ? 8'h04 : 8'h00);
        wr(8'h82, cfg[7:0]);
        for (int s = 0; s < 8; s++) begin
          @(negedge clk); tempStatus = s[2:0];
          settle();
          check("R3 temp gating", {7'b0, irqN},
                {7'b0, !(g[0] && cfg[0] && ((s[2:0] & cfg[3:1]) != 0))});
        end
      end
    tempStatus = '0;

    // R4: voltage sweep (both status groups)
    wr(8'h7C, 8'h04);
    wr(8'h82, 8'h00);
    for (int vg = 0; vg < 2; vg++)
      for (int m = 0; m < 16; m++) begin
        logic [7:0] mask;
        mask = (m == 0) ? 8'h00 : 8'(1 << (m % 8)) ^ (m >= 8 ? 8'hF0 : 8'h00);
        wr(8'h7E, vg[7:0]);
        wr(8'h85, mask);
        for (int s = 0; s < 256; s += 3) begin
          @(negedge clk); {voltStatusB, voltStatusA} = s[7:0];
          settle();
          check("R4 volt gating", {7'b0, irqN},
                {7'b0, !(vg[0] && ((s[7:0] & mask) != 0))});
        end
      end
    {voltStatusB, voltStatusA} = '0;
    wr(8'h7E, 8'h00); wr(8'h85, 8'h00);

    // R5: fan sweep
    for (int cfg = 0; cfg < 32; cfg++) begin
      wr(8'h80, cfg[7:0]);
      for (int s = 0; s < 16; s++) begin
        @(negedge clk); fanStatus = s[3:0];
        settle();
        check("R5 fan gating", {7'b0, irqN},
              {7'b0, !(cfg[0] && ((s[3:0] & cfg[4:1]) != 0))});
      end
    end
    fanStatus = '0;

    // R6: diode faults ignored, readable
    wr(8'h82, 8'h0F); wr(8'h7E, 8'h01); wr(8'h85, 8'hFF); wr(8'h80, 8'h1F);
    for (int f = 0; f < 8; f++) begin
      @(negedge clk); diodeFault = f[2:0];
      settle(); settle();
      check("R6 fault no irq", {7'b0, irqN}, 8'h01);
      rdCheck("R6 fault readback", 8'h86, f[7:0]);
    end
    diodeFault = '0;

    // R1: level held while flag stays set, released after clear
    @(negedge clk); tempStatus = 3'b010;
    settle();
    check("R1 asserted", {7'b0, irqN}, 8'h00);
    repeat (5) settle();
    check("R1 held", {7'b0, irqN}, 8'h00);
    @(negedge clk); tempStatus = '0;
    @(posedge clk); #1;
    check("R1 one-edge latency", {7'b0, irqN}, 8'h01);

    // R7 R8: pin routing sweep
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 2; i++)
        for (int p = 0; p < 4; p++) begin
          wr(8'h7F, r[7:0]);
          @(negedge clk);
          tempStatus = i[0] ? 3'b001 : 3'b000;
          pwm2Gen = p[0]; tach3PadIn = p[1];
          settle();
          check("R7 pwm2Pad", {7'b0, pwm2Pad}, {7'b0, r[1] ? !i[0] : p[0]});
          check("R7 pwm2Oe", {7'b0, pwm2Oe}, 8'h01);
          check("R8 tach3Oe", {7'b0, tach3Oe}, {7'b0, r[0]});
          check("R8 tach3PadOut", {7'b0, tach3PadOut}, {7'b0, r[0] && !i[0]});
          check("R8 tach3ToMon", {7'b0, tach3ToMon}, {7'b0, r[0] ? 1'b1 : p[1]});
        end
    rdCheck("R10 route", 8'h7F, 8'h03);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule